// File: doc/BRIEF.md
# Pixel Raster-Operation Unit

This block sits in the write path of a pixel engine. For each presented pixel it merges a source value with the value already held in the frame buffer. A method code in a 32-bit control word picks one of sixteen bitwise logic functions or one of three wrapping arithmetic functions. The block also decides whether the merged value may be written back. That decision depends on a master update enable and on a selectable set of condition inputs: an inside-clip flag, a mask bit and a sign flag.

Pixels are 24 bits wide. One control bit chooses how arithmetic treats them: either as one 24-bit quantity, or as three independent 8-bit lanes that do not carry into each other. A 3-bit buffer-pair code from the control word is registered next to the result, so that the write stage knows which buffers to update. The result, the write strobe and the buffer code are all registered. They appear one clock after a valid input.

Top module: `pix_rop_unit`

## Requirements
- R1: While reset (active low) is held and after it is released, `rop_result` is 0, `rop_wr` is 0 and `rop_bufsel` is 0 until the first valid input has been registered.
- R2: One clock after a cycle with `px_valid` high, the outputs reflect that cycle's inputs. After a cycle with `px_valid` low, `rop_wr` is 0 and `rop_result` and `rop_bufsel` keep their previous values.
- R3: The method field is `px_ctl[18:12]`. Each logic code produces the following, with S for source and D for destination: 0x60 all zeros; 0x14 S&D; 0x15 S&~D; 0x20 S; 0x16 ~S&D; 0x40 D; 0x11 S^D; 0x0f S|D; 0x17 ~(S|D); 0x10 ~(S^D); 0x4e ~D; 0x0e S|~D; 0x2d ~S; 0x0d ~S|D; 0x0c ~(S&D); 0x6c all ones.
- R4: Arithmetic codes produce: 0x00 S+D; 0x02 S-D; 0x01 D-S.
- R5: `px_ctl[5]`=1 makes arithmetic wrap modulo 2^24. `px_ctl[5]`=0 makes each 8-bit lane (bits 7:0, 15:8, 23:16) wrap modulo 256 with no carry or borrow between lanes.
- R6: Logic codes give the same result whatever the value of `px_ctl[5]`.
- R7: When `px_ctl[0]` is 0, no write strobe is issued, but the result is still produced.
- R8: The condition field `px_ctl[10:8]` gates the strobe. Bit 8 set requires `px_clip_in`=1. Bit 9 set requires `px_mask`=1. Bit 10 set requires `px_sign`=1. When several bits are set, all of the selected conditions must hold. Value 0 always allows the write.
- R9: A method code not listed in R3 or R4 yields the destination unchanged and no write strobe.
- R10: `rop_bufsel` carries `px_ctl[30:28]` when that field is 0, 1, 2 or 4. Any other value is registered as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| px_valid | input | 1 | Inputs are valid this cycle |
| px_ctl | input | 32 | Update control word |
| px_src | input | 24 | Source pixel |
| px_dst | input | 24 | Destination pixel read from the frame buffer |
| px_clip_in | input | 1 | Pixel lies inside the clip rectangle |
| px_mask | input | 1 | Mask bit for this pixel |
| px_sign | input | 1 | Sign condition for this pixel |
| rop_result | output | 24 | Registered merged pixel |
| rop_wr | output | 1 | Registered write strobe |
| rop_bufsel | output | 3 | Registered buffer-pair code |

## Verification
Arithmetic at lane boundaries is the hardest case to reach. A carry or a borrow must cross a lane edge in one plane mode and be stopped in the other. Random 24-bit operands rarely line up that way. Directed operands with 0xFF and 0x00 lane patterns are therefore run in both modes. The random stimulus draws method codes from the legal list and from the unlisted values, and it draws every combination of condition bits and condition inputs, so that each gating path is taken with the strobe both allowed and blocked.

// File: rtl/pix_rop_pkg.sv
package pix_rop_pkg;
    localparam int CTL_W     = 32;
    localparam int EN_BIT    = 0;
    localparam int PLANE_BIT = 5;
    localparam int COND_LSB  = 8;
    localparam int COND_W    = 3;
    localparam int METH_LSB  = 12;
    localparam int METH_W    = 7;
    localparam int BUF_LSB   = 28;
    localparam int BUF_W     = 3;

    typedef enum logic [METH_W-1:0] {
        OP_ZERO   = 7'h60,
        OP_AND    = 7'h14,
        OP_ANDR   = 7'h15,
        OP_COPY   = 7'h20,
        OP_ANDI   = 7'h16,
        OP_KEEP   = 7'h40,
        OP_XOR    = 7'h11,
        OP_OR     = 7'h0f,
        OP_NOR    = 7'h17,
        OP_XNOR   = 7'h10,
        OP_NOTD   = 7'h4e,
        OP_ORR    = 7'h0e,
        OP_NOTS   = 7'h2d,
        OP_ORI    = 7'h0d,
        OP_NAND   = 7'h0c,
        OP_ONES   = 7'h6c,
        OP_ADD    = 7'h00,
        OP_SUB    = 7'h02,
        OP_RSUB   = 7'h01
    } rop_code_e;
endpackage

// File: rtl/rop_logic.sv
module rop_logic
    import pix_rop_pkg::*;
#(
    parameter int PIX_W = 24
) (
    input  logic [METH_W-1:0] code,
    input  logic [PIX_W-1:0]  s,
    input  logic [PIX_W-1:0]  d,
    output logic [PIX_W-1:0]  res,
    output logic              hit
);
    always_comb begin
        hit = 1'b1;
        res = d;
        case (code)
            OP_ZERO: res = '0;
            OP_AND:  res = s & d;
            OP_ANDR: res = s & ~d;
            OP_COPY: res = s;
            OP_ANDI: res = ~s & d;
            OP_KEEP: res = d;
            OP_XOR:  res = s ^ d;
            OP_OR:   res = s | d;
            OP_NOR:  res = ~(s | d);
            OP_XNOR: res = ~(s ^ d);
            OP_NOTD: res = ~d;
            OP_ORR:  res = s | ~d;
            OP_NOTS: res = ~s;
            OP_ORI:  res = ~s | d;
            OP_NAND: res = ~(s & d);
            OP_ONES: res = '1;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/rop_arith.sv
module rop_arith
    import pix_rop_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int LANES  = 3
) (
    input  logic [METH_W-1:0]       code,
    input  logic                    wide,
    input  logic [LANE_W*LANES-1:0] s,
    input  logic [LANE_W*LANES-1:0] d,
    output logic [LANE_W*LANES-1:0] res,
    output logic                    hit
);
    localparam int PIX_W = LANE_W * LANES;

    logic [PIX_W-1:0] full_r;
    logic [PIX_W-1:0] lane_r;

    always_comb begin
        hit = 1'b1;
        full_r = d;
        case (code)
            OP_ADD:  full_r = s + d;
            OP_SUB:  full_r = s - d;
            OP_RSUB: full_r = d - s;
            default: hit = 1'b0;
        endcase
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W-1:0] a, b;
        assign a = s[i*LANE_W +: LANE_W];
        assign b = d[i*LANE_W +: LANE_W];
        assign lane_r[i*LANE_W +: LANE_W] =
            (code == OP_ADD)  ? a + b :
            (code == OP_SUB)  ? a - b :
            (code == OP_RSUB) ? b - a : b;
    end

    assign res = wide ? full_r : lane_r;
endmodule

// File: rtl/rop_wgate.sv
module rop_wgate
    import pix_rop_pkg::*;
(
    input  logic [COND_W-1:0] cond,
    input  logic              clip_in,
    input  logic              mask_in,
    input  logic              sign_in,
    output logic              pass
);
    logic [COND_W-1:0] met;
    assign met  = {sign_in, mask_in, clip_in};
    assign pass = &(met | ~cond);
endmodule

// File: rtl/pix_rop_unit.sv
module pix_rop_unit
    import pix_rop_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int LANES  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    px_valid,
    input  logic [CTL_W-1:0]        px_ctl,
    input  logic [LANE_W*LANES-1:0] px_src,
    input  logic [LANE_W*LANES-1:0] px_dst,
    input  logic                    px_clip_in,
    input  logic                    px_mask,
    input  logic                    px_sign,
    output logic [LANE_W*LANES-1:0] rop_result,
    output logic                    rop_wr,
    output logic [BUF_W-1:0]        rop_bufsel
);
    localparam int PIX_W = LANE_W * LANES;

    typedef struct packed {
        logic [PIX_W-1:0] res;
        logic             wr;
        logic [BUF_W-1:0] bsel;
    } rop_state_t;

    rop_state_t st_d, st_q;

    logic [METH_W-1:0] meth;
    logic [COND_W-1:0] cond;
    logic [BUF_W-1:0]  bfield;
    logic              wide, upd_en;
    logic [PIX_W-1:0]  log_res, ari_res;
    logic              log_hit, ari_hit, gate_ok, buf_legal;
    logic              unused_ctl_bits;

    assign meth   = px_ctl[METH_LSB +: METH_W];
    assign cond   = px_ctl[COND_LSB +: COND_W];
    assign bfield = px_ctl[BUF_LSB +: BUF_W];
    assign wide   = px_ctl[PLANE_BIT];
    assign upd_en = px_ctl[EN_BIT];
    assign unused_ctl_bits = ^{px_ctl[4:1], px_ctl[7:6], px_ctl[11],
                               px_ctl[27:19], px_ctl[31]};

    rop_logic #(.PIX_W(PIX_W)) u_logic (
        .code(meth), .s(px_src), .d(px_dst), .res(log_res), .hit(log_hit)
    );

    rop_arith #(.LANE_W(LANE_W), .LANES(LANES)) u_arith (
        .code(meth), .wide(wide), .s(px_src), .d(px_dst),
        .res(ari_res), .hit(ari_hit)
    );

    rop_wgate u_gate (
        .cond(cond), .clip_in(px_clip_in), .mask_in(px_mask),
        .sign_in(px_sign), .pass(gate_ok)
    );

    always_comb begin
        case (bfield)
            3'd0, 3'd1, 3'd2, 3'd4: buf_legal = 1'b1;
            default:                buf_legal = 1'b0;
        endcase
    end

    always_comb begin
        st_d    = st_q;
        st_d.wr = 1'b0;
        if (px_valid) begin
            st_d.res  = log_hit ? log_res : (ari_hit ? ari_res : px_dst);
            st_d.wr   = upd_en & (log_hit | ari_hit) & gate_ok;
            st_d.bsel = buf_legal ? bfield : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rop_result = st_q.res;
    assign rop_wr     = st_q.wr;
    assign rop_bufsel = st_q.bsel;

    AST_IDLE_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !px_valid |=> !rop_wr); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !px_valid |=> $stable(rop_result)); // R2
    AST_KEEP_DST: assert property (@(posedge clk) disable iff (!rst_n)
        px_valid && meth == OP_KEEP |=> rop_result == $past(px_dst)); // R3
    AST_OFF_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        px_valid && !px_ctl[EN_BIT] |=> !rop_wr); // R7
    AST_CLIP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        px_valid && px_ctl[COND_LSB] && !px_clip_in |=> !rop_wr); // R8
    AST_SIGN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        px_valid && px_ctl[COND_LSB+2] && !px_sign |=> !rop_wr); // R8
    AST_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        px_valid && !log_hit && !ari_hit |=> !rop_wr && rop_result == $past(px_dst)); // R9
    AST_BUF_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        px_valid && bfield == 3'd3 |=> rop_bufsel == '0); // R10
endmodule

// File: tb/tb_pix_rop_unit.sv
module tb_pix_rop_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        px_valid = 1'b0;
    logic [31:0] px_ctl = '0;
    logic [23:0] px_src = '0, px_dst = '0;
    logic        px_clip_in = 1'b0, px_mask = 1'b0, px_sign = 1'b0;
    logic [23:0] rop_result;
    logic        rop_wr;
    logic [2:0]  rop_bufsel;

    int checks = 0;
    int errors = 0;
    logic [23:0] e_res = '0;
    logic [2:0]  e_buf = '0;

    always #10 clk = ~clk;

    pix_rop_unit dut (
        .clk(clk), .rst_n(rst_n), .px_valid(px_valid), .px_ctl(px_ctl),
        .px_src(px_src), .px_dst(px_dst), .px_clip_in(px_clip_in),
        .px_mask(px_mask), .px_sign(px_sign), .rop_result(rop_result),
        .rop_wr(rop_wr), .rop_bufsel(rop_bufsel)
    );

    function automatic logic [31:0] mk(logic [6:0] m, logic pl, logic [2:0] c,
                                       logic en, logic [2:0] b);
        return {1'b0, b, 9'd0, m, 1'b0, c, 2'b0, pl, 4'b0, en};
    endfunction

    function automatic logic known(logic [6:0] m);
        case (m)
            7'h60, 7'h14, 7'h15, 7'h20, 7'h16, 7'h40, 7'h11, 7'h0f, 7'h17,
            7'h10, 7'h4e, 7'h0e, 7'h2d, 7'h0d, 7'h0c, 7'h6c,
            7'h00, 7'h02, 7'h01: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [23:0] model(logic [31:0] c, logic [23:0] s, logic [23:0] d);
        logic [23:0] r;
        logic [6:0] m = c[18:12];
        case (m)
            7'h60: r = 24'h0;        7'h14: r = s & d;
            7'h15: r = s & ~d;       7'h20: r = s;
            7'h16: r = ~s & d;       7'h40: r = d;
            7'h11: r = s ^ d;        7'h0f: r = s | d;
            7'h17: r = ~(s | d);     7'h10: r = ~(s ^ d);
            7'h4e: r = ~d;           7'h0e: r = s | ~d;
            7'h2d: r = ~s;           7'h0d: r = ~s | d;
            7'h0c: r = ~(s & d);     7'h6c: r = 24'hFFFFFF;
            7'h00, 7'h02, 7'h01: begin
                if (c[5]) begin
                    r = (m == 7'h00) ? s + d : (m == 7'h02) ? s - d : d - s;
                end else begin
                    for (int k = 0; k < 3; k++) begin
                        logic [7:0] a = s[k*8 +: 8];
                        logic [7:0] b = d[k*8 +: 8];
                        r[k*8 +: 8] = (m == 7'h00) ? a + b : (m == 7'h02) ? a - b : b - a;
                    end
                end
            end
            default: r = d;
        endcase
        return r;
    endfunction

    function automatic logic mwr(logic [31:0] c, logic cl, logic mk_, logic sg);
        logic ok = 1'b1;
        if (c[8] && !cl)  ok = 1'b0;
        if (c[9] && !mk_) ok = 1'b0;
        if (c[10] && !sg) ok = 1'b0;
        return c[0] & known(c[18:12]) & ok;
    endfunction

    function automatic logic [2:0] mbuf(logic [31:0] c);
        logic [2:0] b = c[30:28];
        return (b == 3'd0 || b == 3'd1 || b == 3'd2 || b == 3'd4) ? b : 3'd0;
    endfunction

    task automatic chk(string tag, logic [23:0] er, logic ew, logic [2:0] eb);
        checks++;
        if (rop_result !== er || rop_wr !== ew || rop_bufsel !== eb) begin
            errors++;
            $display("FAIL %s: got res=%h wr=%b buf=%0d expected res=%h wr=%b buf=%0d",
                     tag, rop_result, rop_wr, rop_bufsel, er, ew, eb);
        end
    endtask

    // drive at a negative edge, check at the following negative edge
    task automatic step(string tag, logic v, logic [31:0] c, logic [23:0] s,
                        logic [23:0] d, logic cl, logic mk_, logic sg);
        logic ew;
        px_valid = v; px_ctl = c; px_src = s; px_dst = d;
        px_clip_in = cl; px_mask = mk_; px_sign = sg;
        ew = 1'b0;
        if (v) begin
            e_res = model(c, s, d);
            e_buf = mbuf(c);
            ew = mwr(c, cl, mk_, sg);
        end
        @(negedge clk);
        chk(tag, e_res, ew, e_buf);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R1 in reset", 24'h0, 1'b0, 3'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", 24'h0, 1'b0, 3'd0);

        step("R3 keep", 1, mk(7'h40, 0, 0, 1, 0), 24'h123456, 24'hABCDEF, 0, 0, 0);
        step("R2 idle hold", 0, mk(7'h6c, 0, 0, 1, 0), 24'h0, 24'h0, 1, 1, 1);
        step("R6 ones lane mode", 1, mk(7'h6c, 0, 0, 1, 1), 24'h0, 24'h0, 0, 0, 0);
        step("R6 xor wide", 1, mk(7'h11, 1, 0, 1, 2), 24'hF0F0F0, 24'h0FF00F, 0, 0, 0);
        step("R5 lane add", 1, mk(7'h00, 0, 0, 1, 4), 24'hFF80FF, 24'h018001, 0, 0, 0);
        step("R5 wide add", 1, mk(7'h00, 1, 0, 1, 0), 24'hFF80FF, 24'h018001, 0, 0, 0);
        step("R4 lane sub", 1, mk(7'h02, 0, 0, 1, 0), 24'h000100, 24'h000001, 0, 0, 0);
        step("R4 wide sub", 1, mk(7'h02, 1, 0, 1, 0), 24'h000100, 24'h000001, 0, 0, 0);
        step("R4 rsub", 1, mk(7'h01, 0, 0, 1, 0), 24'h050505, 24'h030A01, 0, 0, 0);
        step("R7 enable off", 1, mk(7'h20, 0, 0, 0, 0), 24'h777777, 24'h0, 1, 1, 1);
        step("R8 clip blocks", 1, mk(7'h20, 0, 3'b001, 1, 0), 24'h1, 24'h2, 0, 1, 1);
        step("R8 all met", 1, mk(7'h20, 0, 3'b111, 1, 0), 24'h1, 24'h2, 1, 1, 1);
        step("R8 sign blocks", 1, mk(7'h20, 0, 3'b110, 1, 0), 24'h1, 24'h2, 1, 1, 0);
        step("R9 unknown", 1, mk(7'h7f, 0, 0, 1, 0), 24'h111111, 24'h2468AC, 1, 1, 1);
        step("R10 illegal buf", 1, mk(7'h20, 0, 0, 1, 3'd6), 24'h3, 24'h4, 0, 0, 0);

        for (int i = 0; i < 600; i++) begin
            logic [6:0] m;
            logic [6:0] tbl [19] = '{7'h60, 7'h14, 7'h15, 7'h20, 7'h16, 7'h40, 7'h11,
                                     7'h0f, 7'h17, 7'h10, 7'h4e, 7'h0e, 7'h2d, 7'h0d,
                                     7'h0c, 7'h6c, 7'h00, 7'h02, 7'h01};
            m = ($urandom % 5 == 0) ? 7'($urandom) : tbl[$urandom % 19];
            step("R2 random", ($urandom % 6) != 0,
                 mk(m, 1'($urandom), 3'($urandom), ($urandom % 4) != 0, 3'($urandom)),
                 24'($urandom), 24'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule